// File: doc/BRIEF.md
# Video Memory DMA Engine

This block is the transfer engine of a video display processor. Once a command with its start bit arrives, it moves data into one of three on-chip memories: the byte-addressed video RAM, the 64-entry colour RAM or the 64-entry vertical-scroll RAM. The upper two bits of the highest source register choose the kind of transfer:

- **Bus fetch.** Words come from an external bus through a request/valid handshake.
- **Fill.** One byte is written repeatedly across video RAM. It waits for the next data-port write and uses the high byte of that word.
- **Copy.** Bytes are copied from one video RAM location to another.

The surrounding register file provides the length, source, auto-increment, target and start-address values. It reads back the live destination address, remaining length and low source word that the engine keeps updating as it runs.

The engine handles one unit per clock whenever it is not waiting on the bus. Each unit is a word for a bus fetch and a byte for a fill or a copy. Memory writes come out on a single write port that carries a target code and a byte-mode flag. Copy reads use a separate combinational video-RAM byte port.

Top module: `vram_dma_engine`

## Requirements
- R1: A command is accepted only when `cmd_start` and `dma_en` are both high in the same cycle and no transfer is running. Otherwise there are no writes, no bus request and no change to the `len_out`/`addr_out`/`src_out` values.
- R2: The mode comes from `src_hi[7:6]`:
  - 0x selects a bus fetch, and `src_hi[6]` is then a source address bit.
  - 10 selects a fill.
  - 11 selects a copy.
- R3: The length is `{len_hi,len_lo}` words or bytes, and 0 means 65536. `len_out` counts down by one per unit and reads 0 at completion.
- R4: After each unit the destination address advances by `inc`, modulo 65536.
- R5: In a bus fetch into video RAM (`mem_tgt`=1), the word is written at byte address `addr`. When `addr` is odd, its two bytes are swapped.
- R6: In a bus fetch into colour RAM (`mem_tgt`=2) or vertical-scroll RAM (`mem_tgt`=3), `mem_addr` is `addr[6:1]` zero-extended, which is the word index modulo 64. A bus fetch with target 0 performs the handshake but writes nothing.
- R7: In a bus fetch, `bus_req` stays high with `bus_addr` = `{src_hi[6:0], src, 1'b0}`. Each word is written only in a cycle where `bus_valid` is high, and `bus_addr` stays stable while waiting.
- R8: A fill stays armed until `data_wr`, and nothing is written before then. It then writes `data_in[15:8]` as a byte (`mem_byte`=1, data in `mem_wdata[7:0]`, upper byte 0) to each destination address. If the target is not video RAM, nothing is written but the address still advances.
- R9: A copy reads the video RAM byte at `cpy_addr` = the current low source word (wrapping at 16 bits). It writes that byte in byte mode to video RAM at the destination address.
- R10: The low source word `src_out` advances by one per unit. At completion it equals the start value plus the length, modulo 65536.
- R11: `busy` is high exactly while a fill or copy is moving data. It stays low while a fill is armed and during a bus fetch.
- R12: `done` is a one-cycle pulse in the cycle after the last write. In that cycle `busy` and `bus_req` are low.
- R13: After reset, `busy`, `done`, `bus_req` and `mem_we` are low, and `len_out`, `addr_out` and `src_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_en | input | 1 | DMA enable from mode register |
| cmd_start | input | 1 | Command with start bit written |
| len_lo | input | 8 | Length low byte |
| len_hi | input | 8 | Length high byte |
| src_lo | input | 8 | Source bits 7:0 |
| src_mid | input | 8 | Source bits 15:8 |
| src_hi | input | 8 | Mode bits 7:6, source high bits 6:0 |
| inc | input | 8 | Auto-increment |
| target | input | 2 | 0 none, 1 video RAM, 2 colour RAM, 3 vertical-scroll RAM |
| addr_in | input | 16 | Start destination address |
| data_wr | input | 1 | Data-port write strobe |
| data_in | input | 16 | Data-port write word |
| bus_req | output | 1 | External read request |
| bus_addr | output | 24 | External byte address |
| bus_valid | input | 1 | External read data valid |
| bus_data | input | 16 | External read data |
| cpy_addr | output | 16 | Video RAM byte read address |
| cpy_rdata | input | 8 | Video RAM byte read data |
| mem_we | output | 1 | Memory write strobe |
| mem_tgt | output | 2 | Memory written (target encoding) |
| mem_addr | output | 16 | Byte address or cell index |
| mem_wdata | output | 16 | Write data |
| mem_byte | output | 1 | Byte write of mem_wdata[7:0] |
| busy | output | 1 | Fill or copy moving data |
| done | output | 1 | Completion pulse |
| addr_out | output | 16 | Live destination address |
| len_out | output | 16 | Live remaining length |
| src_out | output | 16 | Live low source word |

## Verification
A wrong remaining count shows up at completion. Either `done` arrives after the wrong number of writes, or `len_out` is not zero when it fires. A count that is off at the start is therefore hidden until the end of the transfer, which can be up to 65536 units later. A wrong destination address or source word shows on the very next `mem_addr`, `bus_addr` or `cpy_addr`, so each write is compared against an independently computed sequence. A wrong mode or armed state shows within one cycle as `busy`, `bus_req` or an early write.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [1:0] {XF_BUS = 2'd0, XF_FILL = 2'd2, XF_COPY = 2'd3} xfer_e;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_VRAM = 2'd1, TGT_CRAM = 2'd2, TGT_VSRAM = 2'd3} tgt_e;

  localparam int CELL_W = 6;

  // Mode from the top two bits of the highest source register.
  function automatic xfer_e decode_mode(input logic [1:0] top);
    if (!top[1]) return XF_BUS;
    return top[0] ? XF_COPY : XF_FILL;
  endfunction

  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // Word index modulo 64 for the small memories.
  function automatic logic [15:0] cell_index(input logic [15:0] a);
    return {{(16-CELL_W){1'b0}}, a[CELL_W:1]};
  endfunction

  function automatic logic [15:0] advance(input logic [15:0] a, input logic [7:0] step);
    return a + {8'h00, step};
  endfunction

endpackage

// File: rtl/vdma_counters.sv
module vdma_counters #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_ld,
  input  logic [AW-1:0] len_ld,
  input  logic [AW-1:0] src_ld,
  input  logic [BW-1:0] inc_ld,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] src_q,
  output logic [BW-1:0] inc_q,
  output logic          last
);
  import vdma_pkg::*;

  // A loaded zero wraps to all ones on the first unit: 65536 units in total.
  assign last = (len_q == AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      src_q  <= '0;
      inc_q  <= '0;
    end else if (load) begin
      addr_q <= addr_ld;
      len_q  <= len_ld;
      src_q  <= src_ld;
      inc_q  <= inc_ld;
    end else if (step) begin
      addr_q <= advance(addr_q, inc_q);
      len_q  <= len_q - AW'(1);
      src_q  <= src_q + AW'(1);
    end
  end

endmodule

// File: rtl/vdma_sequencer.sv
module vdma_sequencer (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_req,
  input  vdma_pkg::xfer_e      new_mode,
  input  logic                 fill_trig,
  input  logic                 step,
  input  logic                 last,
  output vdma_pkg::xfer_e      mode_q,
  output logic                 running,
  output logic                 armed,
  output logic                 load,
  output logic                 fill_go,
  output logic                 done
);
  import vdma_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} st_e;
  st_e st_q;

  assign running = (st_q == ST_RUN);
  assign armed   = (st_q == ST_ARMED);
  assign load    = accept_req && !running;
  assign fill_go = armed && fill_trig && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= XF_BUS;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        mode_q <= new_mode;
        st_q   <= (new_mode == XF_FILL) ? ST_ARMED : ST_RUN;
      end else if (fill_go) begin
        st_q <= ST_RUN;
      end else if (running && step && last) begin
        st_q <= ST_IDLE;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vdma_write_fmt.sv
module vdma_write_fmt #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter bit SWAP_ODD = 1'b1
) (
  input  logic                 step,
  input  vdma_pkg::xfer_e      mode,
  input  vdma_pkg::tgt_e       tgt,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        bus_word,
  input  logic [DW/2-1:0]      fill_byte,
  input  logic [DW/2-1:0]      copy_byte,
  output logic                 we,
  output logic [1:0]           wtgt,
  output logic [AW-1:0]        waddr,
  output logic [DW-1:0]        wdata,
  output logic                 wbyte
);
  import vdma_pkg::*;

  localparam int HB = DW / 2;
  logic [DW-1:0] vram_word;

  generate
    if (SWAP_ODD) begin : g_swap
      assign vram_word = addr[0] ? swap_bytes(bus_word) : bus_word;
    end else begin : g_noswap
      assign vram_word = bus_word;
    end
  endgenerate

  always_comb begin
    we    = 1'b0;
    wtgt  = TGT_VRAM;
    waddr = addr;
    wdata = '0;
    wbyte = 1'b1;
    unique case (mode)
      XF_BUS: begin
        wbyte = 1'b0;
        wtgt  = tgt;
        we    = step && (tgt != TGT_NONE);
        if (tgt == TGT_VRAM) begin
          wdata = vram_word;
        end else begin
          waddr = cell_index(addr);
          wdata = bus_word;
        end
      end
      XF_FILL: begin
        we    = step && (tgt == TGT_VRAM);
        wdata = {{HB{1'b0}}, fill_byte};
      end
      XF_COPY: begin
        we    = step;
        wdata = {{HB{1'b0}}, copy_byte};
      end
      default: we = 1'b0;
    endcase
  end

endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine #(
  parameter int AW = 16,
  parameter int BW = 8,
  localparam int DW = 2 * BW,
  localparam int BUS_AW = AW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          cmd_start,
  input  logic [BW-1:0] len_lo,
  input  logic [BW-1:0] len_hi,
  input  logic [BW-1:0] src_lo,
  input  logic [BW-1:0] src_mid,
  input  logic [BW-1:0] src_hi,
  input  logic [BW-1:0] inc,
  input  logic [1:0]    target,
  input  logic [AW-1:0] addr_in,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  output logic          bus_req,
  output logic [BUS_AW-1:0] bus_addr,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] cpy_addr,
  input  logic [BW-1:0] cpy_rdata,
  output logic          mem_we,
  output logic [1:0]    mem_tgt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_byte,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] len_out,
  output logic [AW-1:0] src_out
);
  import vdma_pkg::*;

  // Named internal events, used by the bound checker.
  logic          accept_req, load, fill_go, running, armed, step, last;
  xfer_e         mode_q;
  tgt_e          tgt_q;
  logic [BW-2:0] src_top_q;
  logic [BW-1:0] fill_q;
  logic [BW-1:0] inc_q;

  assign accept_req = cmd_start && dma_en;
  assign step       = running && ((mode_q != XF_BUS) || bus_valid);

  vdma_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .accept_req(accept_req),
    .new_mode(decode_mode(src_hi[BW-1:BW-2])), .fill_trig(data_wr),
    .step(step), .last(last), .mode_q(mode_q), .running(running),
    .armed(armed), .load(load), .fill_go(fill_go), .done(done)
  );

  vdma_counters #(.AW(AW), .BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .addr_ld(addr_in), .len_ld({len_hi, len_lo}), .src_ld({src_mid, src_lo}),
    .inc_ld(inc), .addr_q(addr_out), .len_q(len_out), .src_q(src_out),
    .inc_q(inc_q), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q     <= TGT_NONE;
      src_top_q <= '0;
      fill_q    <= '0;
    end else begin
      if (load) begin
        tgt_q     <= tgt_e'(target);
        src_top_q <= src_hi[BW-2:0];
      end
      if (fill_go) fill_q <= data_in[DW-1:BW];
    end
  end

  assign bus_req  = running && (mode_q == XF_BUS);
  assign bus_addr = {src_top_q, src_out, 1'b0};
  assign cpy_addr = src_out;
  assign busy     = running && (mode_q != XF_BUS);

  vdma_write_fmt #(.AW(AW), .DW(DW), .SWAP_ODD(1'b1)) u_fmt (
    .step(step), .mode(mode_q), .tgt(tgt_q), .addr(addr_out),
    .bus_word(bus_data), .fill_byte(fill_q), .copy_byte(cpy_rdata),
    .we(mem_we), .wtgt(mem_tgt), .waddr(mem_addr), .wdata(mem_wdata),
    .wbyte(mem_byte)
  );

endmodule

// File: rtl/vdma_checker.sv
module vdma_checker #(
  parameter int AW = 16,
  parameter int BUS_AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_valid,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              mem_we,
  input logic              busy,
  input logic              done,
  input logic [AW-1:0]     len_out,
  input logic [AW-1:0]     src_out
);

  assert_write_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && mem_we) |-> bus_valid);

  assert_wait_holds_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_valid) |=> (bus_req && $stable(bus_addr)));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_req && !mem_we));

  assert_busy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, bus_req}));

  assert_len_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_out == '0));

  assert_src_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (src_out != $past(src_out)));

endmodule

bind vram_dma_engine vdma_checker #(.AW(AW), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_valid(bus_valid),
  .bus_addr(bus_addr), .mem_we(mem_we), .busy(busy), .done(done),
  .len_out(len_out), .src_out(src_out)
);

// File: tb/vram_dma_engine_tb.sv
module vram_dma_engine_tb;

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  tgt;
    logic [15:0] addr;
    logic [7:0]  inc;
    logic [15:0] len;
    logic [15:0] src;
    logic [6:0]  hi;
    logic [7:0]  fill;
  } vec_t;

  typedef struct packed {
    logic [1:0]  tgt;
    logic [15:0] addr;
    logic [15:0] data;
    logic        byt;
  } wr_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{md:2'd0, tgt:2'd1, addr:16'h0100, inc:8'd2, len:16'd4, src:16'h1000, hi:7'h05, fill:8'h00},
    '{md:2'd1, tgt:2'd1, addr:16'h0201, inc:8'd2, len:16'd3, src:16'h2222, hi:7'h45, fill:8'h00},
    '{md:2'd0, tgt:2'd2, addr:16'h007C, inc:8'd2, len:16'd4, src:16'hFFFE, hi:7'h00, fill:8'h00},
    '{md:2'd0, tgt:2'd3, addr:16'h0010, inc:8'd4, len:16'd3, src:16'h0040, hi:7'h11, fill:8'h00},
    '{md:2'd3, tgt:2'd2, addr:16'h0400, inc:8'd1, len:16'd5, src:16'hFFFD, hi:7'h00, fill:8'h00},
    '{md:2'd2, tgt:2'd1, addr:16'h0300, inc:8'd1, len:16'd4, src:16'h0500, hi:7'h00, fill:8'hAB},
    '{md:2'd2, tgt:2'd1, addr:16'hFFFE, inc:8'd3, len:16'd3, src:16'hFFFF, hi:7'h00, fill:8'h5C},
    '{md:2'd2, tgt:2'd2, addr:16'h0020, inc:8'd2, len:16'd6, src:16'h0010, hi:7'h00, fill:8'h77},
    '{md:2'd0, tgt:2'd1, addr:16'hFFFE, inc:8'd2, len:16'd2, src:16'h0100, hi:7'h7F, fill:8'h00},
    '{md:2'd0, tgt:2'd0, addr:16'h0050, inc:8'd2, len:16'd2, src:16'h0300, hi:7'h02, fill:8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 1'b0, cmd_start = 1'b0, data_wr = 1'b0, bus_valid = 1'b0;
  logic [7:0] len_lo = '0, len_hi = '0, src_lo = '0, src_mid = '0, src_hi = '0, inc = '0;
  logic [1:0] target = '0;
  logic [15:0] addr_in = '0, data_in = '0;
  logic bus_req, mem_we, mem_byte, busy, done;
  logic [23:0] bus_addr;
  logic [15:0] bus_data, cpy_addr, mem_addr, mem_wdata, addr_out, len_out, src_out;
  logic [7:0] cpy_rdata;
  logic [1:0] mem_tgt;

  int checks = 0, fails = 0, got_n = 0, cyc = 0;
  vec_t cur;

  always #2.5 clk = ~clk;

  // Bench-side memory models.
  assign bus_data  = bus_addr[16:1] ^ {bus_addr[23:17], 9'h000} ^ 16'h3C5A;
  assign cpy_rdata = cpy_addr[7:0] ^ {cpy_addr[11:8], cpy_addr[15:12]} ^ 8'h96;

  vram_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .cmd_start(cmd_start),
    .len_lo(len_lo), .len_hi(len_hi), .src_lo(src_lo), .src_mid(src_mid),
    .src_hi(src_hi), .inc(inc), .target(target), .addr_in(addr_in),
    .data_wr(data_wr), .data_in(data_in), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .bus_data(bus_data), .cpy_addr(cpy_addr),
    .cpy_rdata(cpy_rdata), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_byte(mem_byte), .busy(busy), .done(done),
    .addr_out(addr_out), .len_out(len_out), .src_out(src_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected k-th write, stated from the requirements.
  function automatic wr_t expect_write(input vec_t v, input int k);
    wr_t r;
    logic [15:0] d, s, w;
    d = v.addr + 16'(k) * {8'h00, v.inc};
    s = v.src + 16'(k);
    r.addr = d;
    if (!v.md[1]) begin
      w = s ^ {v.hi, 9'h000} ^ 16'h3C5A;
      r.tgt = v.tgt;
      r.byt = 1'b0;
      if (v.tgt == 2'd1) r.data = d[0] ? {w[7:0], w[15:8]} : w;
      else begin r.data = w; r.addr = {10'h000, d[6:1]}; end
    end else begin
      r.tgt = 2'd1;
      r.byt = 1'b1;
      if (v.md[0]) r.data = {8'h00, s[7:0] ^ {s[11:8], s[15:12]} ^ 8'h96};
      else         r.data = {8'h00, v.fill};
    end
    return r;
  endfunction

  function automatic int expect_count(input vec_t v);
    int n;
    n = (v.len == 16'd0) ? 65536 : int'(v.len);
    if (!v.md[1]) return (v.tgt != 2'd0) ? n : 0;
    if (!v.md[0]) return (v.tgt == 2'd1) ? n : 0;
    return n;
  endfunction

  // Bus valid pattern with wait cycles.
  initial forever begin
    @(negedge clk);
    bus_valid = (cyc % 3) != 1;
    cyc++;
  end

  // Write monitor, sampled just before the rising edge.
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && mem_we) begin
      wr_t e;
      e = expect_write(cur, got_n);
      chk("R5/R6/R8/R9 write target", {30'd0, mem_tgt}, {30'd0, e.tgt});
      chk("R4/R6 write address", {16'd0, mem_addr}, {16'd0, e.addr});
      chk("R5/R8/R9 write data", {16'd0, mem_wdata}, {16'd0, e.data});
      chk("R8/R9 byte mode", {31'd0, mem_byte}, {31'd0, e.byt});
      if (bus_req) chk("R7 valid on bus write", {31'd0, bus_valid}, 32'd1);
      got_n++;
    end
  end

  initial begin
    #950000;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic run_vec(input vec_t v);
    logic [15:0] src0, addr0;
    int n;
    cur = v; got_n = 0;
    src0 = v.src; addr0 = v.addr;
    @(negedge clk);
    dma_en = 1'b1; cmd_start = 1'b1;
    {len_hi, len_lo} = v.len; {src_mid, src_lo} = v.src;
    src_hi = {v.md, 6'd0} | {1'b0, v.hi};
    inc = v.inc; target = v.tgt; addr_in = v.addr;
    @(negedge clk);
    cmd_start = 1'b0;
    #2;
    if (v.md == 2'd2) begin
      chk("R8 armed no busy R11", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      #2;
      chk("R8 no write while armed", 32'(got_n), 32'd0);
      @(negedge clk);
      data_wr = 1'b1; data_in = {v.fill, 8'h3D};
      @(negedge clk);
      data_wr = 1'b0;
      #2;
    end
    chk("R11 busy during run", {31'd0, busy}, {31'd0, v.md[1]});
    chk("R2 bus request by mode", {31'd0, bus_req}, {31'd0, !v.md[1]});
    if (!v.md[1]) chk("R7 bus address", {8'd0, bus_addr}, {8'd0, v.hi, src0, 1'b0});
    n = 0;
    while (!done && n < 70000) begin
      @(negedge clk);
      #2;
      n++;
    end
    chk("R12 done pulse seen", {31'd0, done}, 32'd1);
    chk("R12 busy low at done", {31'd0, busy}, 32'd0);
    chk("R3 write count", 32'(got_n), 32'(expect_count(v)));
    chk("R3 length reads zero", {16'd0, len_out}, 32'd0);
    chk("R10 source advanced", {16'd0, src_out}, {16'd0, src0 + v.len});
    chk("R4 address advanced", {16'd0, addr_out}, {16'd0, addr0 + v.len * {8'd0, v.inc}});
    @(negedge clk);
    #2;
    chk("R12 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    vec_t z;
    cur = VECS[0];
    repeat (3) @(negedge clk);
    #2;
    chk("R13 busy reset", {31'd0, busy}, 32'd0);
    chk("R13 done reset", {31'd0, done}, 32'd0);
    chk("R13 bus_req reset", {31'd0, bus_req}, 32'd0);
    chk("R13 len reset", {16'd0, len_out}, 32'd0);
    chk("R13 addr reset", {16'd0, addr_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: start ignored without enable.
    @(negedge clk);
    dma_en = 1'b0; cmd_start = 1'b1; {len_hi, len_lo} = 16'd7;
    src_hi = 8'hC0; addr_in = 16'h1234; inc = 8'd1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 disabled start no busy", {31'd0, busy}, 32'd0);
    chk("R1 disabled start no writes", 32'(got_n), 32'd0);
    chk("R1 disabled start len unchanged", {16'd0, len_out}, 32'd0);
    chk("R1 disabled start addr unchanged", {16'd0, addr_out}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R3: zero length copy moves 65536 bytes.
    z = '{md:2'd3, tgt:2'd1, addr:16'h0800, inc:8'd1, len:16'd0, src:16'h4000, hi:7'h00, fill:8'h00};
    run_vec(z);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule